// File: doc/BRIEF.md
# Dual-Lane Registered Bus Transceiver

This block connects an A-side bus to a B-side bus and splits the data word into independent byte lanes. Each lane has its own control set, made up of a drive enable for each direction, a capture strobe for each direction and a source select for each direction. Inside each lane sit two storage registers. The A-to-B register samples the A bus and the B-to-A register samples the B bus. Each output port can carry either live data from the opposite bus or the word held in its direction's register. If every lane is given the same control values, the lanes behave as one full-width transceiver.

The pads are modelled as separate input, output and output-enable vectors, one bit of each per data line, so the block is synthesizable. Output values always follow the selected source. The output-enable vectors decide whether the pads actually drive. The drive enable for the B side is active high and the drive enable for the A side is active low. The registers sample at the rising edge of the shared clock on which their strobe is high. The enables and selects have no effect on capture. An active-low asynchronous reset clears every register.

Top module: `dual_lane_xcvr`

## Requirements
- R1: While rst_n is low, every storage register is zero, so any output selecting its register reads 0x00 in that lane.
- R2: On a clock rising edge with cap_ab[k] high, lane k's A-to-B register loads a_in lane k. With cap_ab[k] low it keeps its value. Drive enables and selects have no effect on this.
- R3: On a clock rising edge with cap_ba[k] high, lane k's B-to-A register loads b_in lane k. With cap_ba[k] low it keeps its value. Drive enables and selects have no effect on this.
- R4: Every bit of b_oe in lane k equals drv_b_en[k] (active high). Every bit of a_oe in lane k equals the inverse of drv_a_en_n[k] (active low). Both follow their inputs in the same cycle.
- R5: When sel_ab_stored[k] is 0, b_out lane k equals a_in lane k in the same cycle. When it is 1, b_out lane k equals the A-to-B register.
- R6: When sel_ba_stored[k] is 0, a_out lane k equals b_in lane k in the same cycle. When it is 1, a_out lane k equals the B-to-A register.
- R7: When drv_b_en[k]=0 and drv_a_en_n[k]=1, lane k drives neither port (all of its oe bits are 0), and both of its registers still capture.
- R8: Lane k's controls affect only bits [8k+7:8k]. The other lane's outputs, enables and registers are unchanged.
- R9: With both directions enabled and both selects at 1, b_out carries the A-to-B register and a_out carries the B-to-A register at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low register clear |
| drv_b_en | input | LANES | Per-lane B-side drive enable, active high |
| drv_a_en_n | input | LANES | Per-lane A-side drive enable, active low |
| cap_ab | input | LANES | Per-lane strobe loading the A-to-B register |
| cap_ba | input | LANES | Per-lane strobe loading the B-to-A register |
| sel_ab_stored | input | LANES | 1: B port shows the stored word, 0: live A data |
| sel_ba_stored | input | LANES | 1: A port shows the stored word, 0: live B data |
| a_in | input | LANES*LANE_W | Sensed value of the A bus |
| a_out | output | LANES*LANE_W | Value to drive on the A bus |
| a_oe | output | LANES*LANE_W | Per-bit A pad drive enable |
| b_in | input | LANES*LANE_W | Sensed value of the B bus |
| b_out | output | LANES*LANE_W | Value to drive on the B bus |
| b_oe | output | LANES*LANE_W | Per-bit B pad drive enable |

## Verification
Live data paths, selects and drive enables have no register in their path, so their results are due in the same cycle. The bench changes inputs on the falling clock edge and samples one nanosecond later. A captured word is due at the first rising edge on which its strobe is high. The bench clears the strobe at the next falling edge, switches the select to the stored source, and compares the output there. It also checks, before that rising edge, that the old stored word is still present. Hold checks change the bus inputs while the strobes are low and then compare the outputs after a further rising edge.

// File: rtl/dual_lane_xcvr_pkg.sv
package dual_lane_xcvr_pkg;

   // Decoded per-lane controls, all active high
   typedef struct packed {
      logic drive_b;
      logic drive_a;
      logic b_from_reg;
      logic a_from_reg;
   } lane_ctl_t;

   function automatic lane_ctl_t decode_lane(input logic b_en, input logic a_en_n,
                                             input logic ab_sel, input logic ba_sel);
      lane_ctl_t c;
      c.drive_b    = b_en;
      c.drive_a    = ~a_en_n;
      c.b_from_reg = ab_sel;
      c.a_from_reg = ba_sel;
      return c;
   endfunction

endpackage

// File: rtl/dual_lane_xcvr_ctl.sv
module dual_lane_xcvr_ctl
   import dual_lane_xcvr_pkg::*;
(
   input  logic      b_en,
   input  logic      a_en_n,
   input  logic      ab_sel,
   input  logic      ba_sel,
   output lane_ctl_t ctl
);
   assign ctl = decode_lane(b_en, a_en_n, ab_sel, ba_sel);
endmodule

// File: rtl/dual_lane_xcvr_store.sv
module dual_lane_xcvr_store #(
   parameter int  WIDTH     = 8,
   parameter bit  HAS_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("dual_lane_xcvr_store: WIDTH must be at least 1");
   end

   if (HAS_RESET) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= '0;
         else if (load) q <= d;
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         if (load) q <= d;
      end
   end
endmodule

// File: rtl/dual_lane_xcvr_lane.sv
module dual_lane_xcvr_lane
   import dual_lane_xcvr_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter bit HAS_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drv_b_en,
   input  logic              drv_a_en_n,
   input  logic              cap_ab,
   input  logic              cap_ba,
   input  logic              sel_ab_stored,
   input  logic              sel_ba_stored,
   input  logic [LANE_W-1:0] a_in,
   input  logic [LANE_W-1:0] b_in,
   output logic [LANE_W-1:0] a_out,
   output logic [LANE_W-1:0] a_oe,
   output logic [LANE_W-1:0] b_out,
   output logic [LANE_W-1:0] b_oe
);
   lane_ctl_t         ctl;
   logic [LANE_W-1:0] ab_q;
   logic [LANE_W-1:0] ba_q;

   dual_lane_xcvr_ctl u_ctl (
      .b_en   (drv_b_en),
      .a_en_n (drv_a_en_n),
      .ab_sel (sel_ab_stored),
      .ba_sel (sel_ba_stored),
      .ctl    (ctl)
   );

   // Capture is independent of enables and selects
   dual_lane_xcvr_store #(.WIDTH(LANE_W), .HAS_RESET(HAS_RESET)) u_ab (
      .clk (clk), .rst_n (rst_n), .load (cap_ab), .d (a_in), .q (ab_q)
   );

   dual_lane_xcvr_store #(.WIDTH(LANE_W), .HAS_RESET(HAS_RESET)) u_ba (
      .clk (clk), .rst_n (rst_n), .load (cap_ba), .d (b_in), .q (ba_q)
   );

   always_comb begin
      b_out = ctl.b_from_reg ? ab_q : a_in;
      a_out = ctl.a_from_reg ? ba_q : b_in;
      b_oe  = {LANE_W{ctl.drive_b}};
      a_oe  = {LANE_W{ctl.drive_a}};
   end
endmodule

// File: rtl/dual_lane_xcvr.sv
module dual_lane_xcvr #(
   parameter int LANES     = 2,
   parameter int LANE_W    = 8,
   parameter bit HAS_RESET = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES-1:0]          drv_b_en,
   input  logic [LANES-1:0]          drv_a_en_n,
   input  logic [LANES-1:0]          cap_ab,
   input  logic [LANES-1:0]          cap_ba,
   input  logic [LANES-1:0]          sel_ab_stored,
   input  logic [LANES-1:0]          sel_ba_stored,
   input  logic [LANES*LANE_W-1:0]   a_in,
   output logic [LANES*LANE_W-1:0]   a_out,
   output logic [LANES*LANE_W-1:0]   a_oe,
   input  logic [LANES*LANE_W-1:0]   b_in,
   output logic [LANES*LANE_W-1:0]   b_out,
   output logic [LANES*LANE_W-1:0]   b_oe
);
   localparam int BUS_W = LANES * LANE_W;

   if (LANES < 1 || LANE_W < 1 || BUS_W > 4096) begin : g_bad_cfg
      $error("dual_lane_xcvr: LANES and LANE_W must be positive and bus at most 4096 bits");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      dual_lane_xcvr_lane #(.LANE_W(LANE_W), .HAS_RESET(HAS_RESET)) u_lane (
         .clk           (clk),
         .rst_n         (rst_n),
         .drv_b_en      (drv_b_en[k]),
         .drv_a_en_n    (drv_a_en_n[k]),
         .cap_ab        (cap_ab[k]),
         .cap_ba        (cap_ba[k]),
         .sel_ab_stored (sel_ab_stored[k]),
         .sel_ba_stored (sel_ba_stored[k]),
         .a_in          (a_in[k*LANE_W +: LANE_W]),
         .b_in          (b_in[k*LANE_W +: LANE_W]),
         .a_out         (a_out[k*LANE_W +: LANE_W]),
         .a_oe          (a_oe[k*LANE_W +: LANE_W]),
         .b_out         (b_out[k*LANE_W +: LANE_W]),
         .b_oe          (b_oe[k*LANE_W +: LANE_W])
      );
   end
endmodule

// File: rtl/dual_lane_xcvr_chk.sv
module dual_lane_xcvr_chk #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [LANES-1:0]        drv_b_en,
   input logic [LANES-1:0]        drv_a_en_n,
   input logic [LANES-1:0]        cap_ab,
   input logic [LANES-1:0]        cap_ba,
   input logic [LANES-1:0]        sel_ab_stored,
   input logic [LANES-1:0]        sel_ba_stored,
   input logic [LANES*LANE_W-1:0] a_in,
   input logic [LANES*LANE_W-1:0] a_out,
   input logic [LANES*LANE_W-1:0] a_oe,
   input logic [LANES*LANE_W-1:0] b_in,
   input logic [LANES*LANE_W-1:0] b_out,
   input logic [LANES*LANE_W-1:0] b_oe
);
   for (genvar k = 0; k < LANES; k++) begin : g_chk
      assert_load_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
         cap_ab[k] |=> (!sel_ab_stored[k] ||
                        b_out[k*LANE_W +: LANE_W] == $past(a_in[k*LANE_W +: LANE_W])));

      assert_hold_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!cap_ab[k] && sel_ab_stored[k]) |=>
            (!sel_ab_stored[k] || $stable(b_out[k*LANE_W +: LANE_W])));

      assert_load_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
         cap_ba[k] |=> (!sel_ba_stored[k] ||
                        a_out[k*LANE_W +: LANE_W] == $past(b_in[k*LANE_W +: LANE_W])));

      assert_hold_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!cap_ba[k] && sel_ba_stored[k]) |=>
            (!sel_ba_stored[k] || $stable(a_out[k*LANE_W +: LANE_W])));

      assert_oe_pol_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (b_oe[k*LANE_W +: LANE_W] == {LANE_W{drv_b_en[k]}}) &&
         (a_oe[k*LANE_W +: LANE_W] == {LANE_W{!drv_a_en_n[k]}}));

      assert_live_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !sel_ab_stored[k] |-> b_out[k*LANE_W +: LANE_W] == a_in[k*LANE_W +: LANE_W]);

      assert_live_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !sel_ba_stored[k] |-> a_out[k*LANE_W +: LANE_W] == b_in[k*LANE_W +: LANE_W]);
   end
endmodule

bind dual_lane_xcvr dual_lane_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/dual_lane_xcvr_bench.sv
`timescale 1ns/1ps
module dual_lane_xcvr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [1:0]  drv_b_en = '0, drv_a_en_n = 2'b11, cap_ab = '0, cap_ba = '0;
   logic [1:0]  sel_ab_stored = '0, sel_ba_stored = '0;
   logic [15:0] a_in = '0, b_in = '0;
   logic [15:0] a_out, a_oe, b_out, b_oe;
   int          n_checks = 0;
   int          n_errors = 0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   dual_lane_xcvr u_dual_lane_xcvr (
      .clk (clk), .rst_n (rst_n),
      .drv_b_en (drv_b_en), .drv_a_en_n (drv_a_en_n),
      .cap_ab (cap_ab), .cap_ba (cap_ba),
      .sel_ab_stored (sel_ab_stored), .sel_ba_stored (sel_ba_stored),
      .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
      .b_in (b_in), .b_out (b_out), .b_oe (b_oe)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      #1 rst_n = 1'b0;
      sel_ab_stored = 2'b11; sel_ba_stored = 2'b11;
      a_in = 16'hA5A5; b_in = 16'h5A5A;
      #1;
      chk("R1 b_out in reset", b_out, 16'h0000);
      chk("R1 a_out in reset", a_out, 16'h0000);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 b_out after release", b_out, 16'h0000);
      chk("R1 a_out after release", a_out, 16'h0000);
   endtask

   task automatic t_enables();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         drv_b_en   = {~i[1], i[1]};
         drv_a_en_n = {~i[0], i[0]};
         #1;
         // lane0: b_en=i[1], a_en_n=i[0]; lane1 the inverse (R8)
         chk((i == 1) ? "R7 b_oe isolation lane0" : "R4 b_oe",
             b_oe, {{8{~i[1]}}, {8{i[1]}}});
         chk((i == 1) ? "R7 a_oe isolation lane0" : "R4 a_oe",
             a_oe, {{8{i[0]}}, {8{~i[0]}}});
      end
   endtask

   task automatic t_live();
      logic [15:0] pat [3] = '{16'h0000, 16'hF00F, 16'h9C63};
      @(negedge clk);
      sel_ab_stored = '0; sel_ba_stored = '0;
      drv_b_en = 2'b11; drv_a_en_n = 2'b00;
      for (int i = 0; i < 3; i++) begin
         a_in = pat[i]; b_in = ~pat[i];
         #1;
         chk("R5 live A to B", b_out, pat[i]);
         chk("R6 live B to A", a_out, ~pat[i]);
         @(negedge clk);
      end
   endtask

   task automatic t_capture_ab();
      @(negedge clk);
      drv_b_en = 2'b00; drv_a_en_n = 2'b11;   // isolation (R7)
      a_in = 16'h3CC3; cap_ab = 2'b01;
      @(negedge clk);
      cap_ab = 2'b00; a_in = 16'h1111; sel_ab_stored = 2'b01;
      #1;
      chk("R2 R7 R8 lane0 stored, lane1 live", b_out, 16'h11C3);
      @(negedge clk);
      a_in = 16'h2222; @(negedge clk); #1;
      chk("R2 hold without strobe", b_out, 16'h22C3);
      a_in = 16'h7E44; cap_ab = 2'b10;
      @(negedge clk);
      cap_ab = 2'b00; a_in = 16'h0000; sel_ab_stored = 2'b11;
      #1;
      chk("R2 R8 lane1 loaded lane0 kept", b_out, 16'h7EC3);
      sel_ba_stored = 2'b11; #1;
      chk("R3 R8 B-to-A untouched by A strobes", a_out, 16'h0000);
   endtask

   task automatic t_capture_ba();
      @(negedge clk);
      drv_b_en = 2'b01; drv_a_en_n = 2'b10; sel_ba_stored = 2'b00;
      b_in = 16'h9669; cap_ba = 2'b11;
      #1;
      chk("R6 live before capture", a_out, 16'h9669);
      @(negedge clk);
      cap_ba = 2'b00; b_in = 16'h0F0F; sel_ba_stored = 2'b11;
      #1;
      chk("R3 stored B word", a_out, 16'h9669);
      @(negedge clk); b_in = 16'hFFFF; @(negedge clk); #1;
      chk("R3 hold without strobe", a_out, 16'h9669);
   endtask

   task automatic t_both_stored();
      @(negedge clk);
      drv_b_en = 2'b11; drv_a_en_n = 2'b00;
      sel_ab_stored = 2'b11; sel_ba_stored = 2'b11;
      a_in = 16'h1234; b_in = 16'h5678;
      #1;
      chk("R9 b_out from A-to-B store", b_out, 16'h7EC3);
      chk("R9 a_out from B-to-A store", a_out, 16'h9669);
      chk("R9 b_oe on", b_oe, 16'hFFFF);
      chk("R9 a_oe on", a_oe, 16'hFFFF);
      a_in = 16'hBEEF; cap_ab = 2'b11;
      #1;
      chk("R2 not due before edge", b_out, 16'h7EC3);
      @(negedge clk);
      cap_ab = 2'b00; #1;
      chk("R2 due after edge", b_out, 16'hBEEF);
   endtask

   initial begin
      t_reset();
      t_enables();
      t_live();
      t_capture_ab();
      t_capture_ba();
      t_both_stored();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule